// File: doc/BRIEF.md
# Link Status Word with Sticky Event Flags and Negotiation Progress Monitor

This block holds one 16-bit status word of a physical-layer transceiver, as seen by a station-management agent. The agent reads it with a one-cycle read strobe. One cycle later the block presents the word on a read-data bus, together with a valid pulse. The word carries two sticky event flags and a four-bit negotiation progress code.

The two flags record the loss of the 100 Mb/s receive signal and a failure of the receive clock-recovery PLL to lock. Each flag goes high on its event pulse and stays high until the agent has seen it in a read. The progress monitor follows the code driven by an external negotiation state machine. It keeps the furthest stage reached, not the present one. A read returns that furthest stage and, in the same cycle, reloads the monitor with the present live code. The next read therefore starts from where negotiation stood at the previous read.

The monitor is one state register whose states are the nine negotiation stages. Its states are Idle, ParDetected, ParFailed, AbilityMatched, AckFailed, AckMatched, ConsFailed, ConsMatched and Done, with codes 0 to 8 in that order. It has three transitions:
- Advance: it moves to the live stage when that stage has a larger code.
- Hold: it keeps its state otherwise.
- Reload: on a read it jumps to the live stage, or to Idle if the live code is not a legal stage.

Top module: `phy_status_latch`

## Requirements
- R1: The signal-lost flag (word bit 4) goes to 1 on a `sig_lost_evt` pulse and stays 1 through any number of cycles without a read.
- R2: The lock-error flag (word bit 5) goes to 1 on a `pll_fail_evt` pulse and stays 1 through any number of cycles without a read.
- R3: A read returns each flag and then clears it. If the flag's event is asserted in the read cycle itself, that read returns the old value and the flag is 1 again after the read.
- R4: The progress field (word bits 3:0) returns the largest legal code seen on `an_live` from the previous read cycle up to the cycle before this read. The legal codes are Idle 0000, ParDetected 0001, ParFailed 0010, AbilityMatched 0011, AckFailed 0100, AckMatched 0101, ConsFailed 0110, ConsMatched 0111 and Done 1000. Bit 3 is the negotiation-complete bit.
- R5: On a read, the monitor reloads with the `an_live` code of that cycle, so a later read reports at least that stage.
- R6: Live codes 1001 to 1111 never advance the monitor. A read that sees one reloads the monitor to Idle.
- R7: When `mode_10m` is 1 in the read cycle, word bits 5:4 read as 0. The flags are still cleared by that read.
- R8: `rd_valid` is 1 exactly in the cycle after a read strobe. `rd_data` changes only then and holds its value between reads. Word bits 15:6 are always 0.
- R9: A synchronous active-high reset clears both flags, sets the monitor to Idle, and drives `rd_valid` and `rd_data` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | One-cycle read request from the management agent |
| sig_lost_evt | input | 1 | Pulse: 100 Mb/s receive signal lost |
| pll_fail_evt | input | 1 | Pulse: PLL failed to lock onto the receive stream |
| an_live | input | 4 | Present stage code of the external negotiation machine |
| mode_10m | input | 1 | 1 when the link runs at 10 Mb/s |
| rd_data | output | 16 | Status word captured by the last read |
| rd_valid | output | 1 | High for one cycle when `rd_data` holds a fresh word |

## Verification
The bench places events in the same cycle as a read. A design that clears a flag without regard to its event would lose that event, and the next read would show 0 where 1 is due. The bench drives a stage that drops back before a read. A monitor that tracks the live code instead of the maximum would report the lower stage. The bench reads while the live code is at a middle stage and then drives Idle. A design that resets the monitor to Idle on a read, instead of reloading the live code, fails that case.

Further cases cover illegal codes 1001 to 1111, which a design without a legality check would latch as progress. They also cover reads in 10 Mb/s mode, where a design must hide the flags and still clear them. A long random run compares every returned word with the model.

// File: rtl/phy_stat_pkg.sv
package phy_stat_pkg;
    localparam int CODE_W    = 4;
    localparam int WORD_W    = 16;
    localparam int NUM_FLAGS = 2;
    localparam int FLAG_LSB  = CODE_W;
    localparam int USED_W    = CODE_W + NUM_FLAGS;

    typedef enum logic [CODE_W-1:0] {
        AN_IDLE        = 4'd0,
        AN_PAR_DET     = 4'd1,
        AN_PAR_FAIL    = 4'd2,
        AN_ABIL_MATCH  = 4'd3,
        AN_ACK_FAIL    = 4'd4,
        AN_ACK_MATCH   = 4'd5,
        AN_CONS_FAIL   = 4'd6,
        AN_CONS_MATCH  = 4'd7,
        AN_DONE        = 4'd8
    } an_stage_e;
endpackage

// File: rtl/sticky_flag.sv
module sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (clr) flag <= evt;
        else          flag <= flag | evt;
    end

    // R1 / R2: a set flag survives until a read
    assert_flag_sticky_R1: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);
    // R3: an event, even one in a read cycle, leaves the flag set
    assert_evt_not_lost_R3: assert property (@(posedge clk) disable iff (rst)
        evt |=> flag);
endmodule

// File: rtl/progress_monitor.sv
module progress_monitor
    import phy_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic [CODE_W-1:0] live,
    output an_stage_e         stage
);
    an_stage_e cand;
    logic      legal;
    an_stage_e nxt;

    always_comb begin
        legal = 1'b1;
        unique case (live)
            4'd0:    cand = AN_IDLE;
            4'd1:    cand = AN_PAR_DET;
            4'd2:    cand = AN_PAR_FAIL;
            4'd3:    cand = AN_ABIL_MATCH;
            4'd4:    cand = AN_ACK_FAIL;
            4'd5:    cand = AN_ACK_MATCH;
            4'd6:    cand = AN_CONS_FAIL;
            4'd7:    cand = AN_CONS_MATCH;
            4'd8:    cand = AN_DONE;
            default: begin cand = AN_IDLE; legal = 1'b0; end
        endcase
    end

    always_comb begin
        if (rd)                           nxt = cand;      // Reload
        else if (legal && (cand > stage)) nxt = cand;      // Advance
        else                              nxt = stage;     // Hold
    end

    always_ff @(posedge clk) begin
        if (rst) stage <= AN_IDLE;
        else     stage <= nxt;
    end

    // R4: without a read the monitor never moves back
    assert_monotonic_R4: assert property (@(posedge clk) disable iff (rst)
        !rd |=> (stage >= $past(stage)));
    // R5: a read with a legal live code loads that code
    assert_reload_R5: assert property (@(posedge clk) disable iff (rst)
        (rd && live <= 4'd8) |=> (stage == $past(live)));
    // R6: an illegal live code never advances the monitor
    assert_illegal_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (!rd && live > 4'd8) |=> $stable(stage));
endmodule

// File: rtl/phy_status_latch.sv
module phy_status_latch
    import phy_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_stb,
    input  logic              sig_lost_evt,
    input  logic              pll_fail_evt,
    input  logic [CODE_W-1:0] an_live,
    input  logic              mode_10m,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [NUM_FLAGS-1:0] evts;
    logic [NUM_FLAGS-1:0] flags;
    an_stage_e            stage;
    logic [WORD_W-1:0]    word;

    assign evts = {pll_fail_evt, sig_lost_evt};

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        sticky_flag u_flag (
            .clk  (clk),
            .rst  (rst),
            .evt  (evts[g]),
            .clr  (rd_stb),
            .flag (flags[g])
        );
    end

    progress_monitor u_mon (
        .clk   (clk),
        .rst   (rst),
        .rd    (rd_stb),
        .live  (an_live),
        .stage (stage)
    );

    always_comb begin
        word = '0;
        word[CODE_W-1:0]                 = stage;
        word[FLAG_LSB +: NUM_FLAGS]      = mode_10m ? '0 : flags;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_stb;
            if (rd_stb) rd_data <= word;
        end
    end

    // R8: valid follows the strobe by one cycle
    assert_valid_timing_R8: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> rd_valid);
    // R8: the word holds between reads, and its upper bits are 0
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> $stable(rd_data));
    assert_unused_zero_R8: assert property (@(posedge clk) disable iff (rst)
        rd_data[WORD_W-1:USED_W] == '0);
    // R7: in 10 Mb/s mode the flags read as 0
    assert_10m_mask_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && mode_10m) |=> (rd_data[FLAG_LSB +: NUM_FLAGS] == '0));
endmodule

// File: tb/tb_phy_status_latch.sv
`timescale 1ns/1ps
module tb_phy_status_latch;
    logic        clk = 1'b0;
    logic        rst;
    logic        rd_stb, sig_lost_evt, pll_fail_evt, mode_10m;
    logic [3:0]  an_live;
    logic [15:0] rd_data;
    logic        rd_valid;

    always #2.5 clk = ~clk;

    phy_status_latch dut (
        .clk(clk), .rst(rst), .rd_stb(rd_stb), .sig_lost_evt(sig_lost_evt),
        .pll_fail_evt(pll_fail_evt), .an_live(an_live), .mode_10m(mode_10m),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] last_word = '0;
    logic        m_sl = 0, m_pf = 0;
    logic [3:0]  m_prog = 0;
    bit          done = 0;

    // Driver: drives one cycle and pushes the expected word on a read
    task automatic cyc(input logic rd, input logic sl, input logic pf,
                       input logic [3:0] lv, input logic m, input string tag);
        @(negedge clk);
        rd_stb = rd; sig_lost_evt = sl; pll_fail_evt = pf; an_live = lv; mode_10m = m;
        if (rd) begin
            logic [15:0] w;
            w = '0;
            w[3:0] = m_prog;
            w[4]   = m ? 1'b0 : m_sl;
            w[5]   = m ? 1'b0 : m_pf;
            exp_q.push_back(w);
            tag_q.push_back(tag);
            m_sl = sl; m_pf = pf;
            m_prog = (lv <= 4'd8) ? lv : 4'd0;
        end else begin
            m_sl = m_sl | sl; m_pf = m_pf | pf;
            if (lv <= 4'd8 && lv > m_prog) m_prog = lv;
        end
    endtask

    task automatic idle(input int n, input logic [3:0] lv);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, lv, 0, "");
    endtask

    // Monitor: compares every returned word and the hold behaviour
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (rd_valid) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R8: unexpected valid, data=%h expected no word", rd_data);
                end else begin
                    logic [15:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (rd_data !== e) begin
                        errors++;
                        $display("FAIL %s: data=%h expected=%h", t, rd_data, e);
                    end
                end
                last_word = rd_data;
            end else begin
                checks++;
                if (rd_data !== last_word) begin
                    errors++;
                    $display("FAIL R8: data changed without read, got=%h expected=%h",
                             rd_data, last_word);
                end
            end
        end
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: run did not finish, got hang expected end");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst = 1; rd_stb = 0; sig_lost_evt = 0; pll_fail_evt = 0; an_live = 0; mode_10m = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (rd_valid !== 1'b0 || rd_data !== 16'h0) begin
            errors++;
            $display("FAIL R9: valid=%b data=%h expected valid=0 data=0000", rd_valid, rd_data);
        end
        rst = 0;
        cyc(1, 0, 0, 0, 0, "R9 read after reset");
        idle(2, 0);
        // R1 signal-lost is sticky
        cyc(0, 1, 0, 0, 0, ""); idle(5, 0);
        cyc(1, 0, 0, 0, 0, "R1 sticky signal-lost");
        cyc(1, 0, 0, 0, 0, "R3 cleared after read");
        // R2 lock error is sticky
        cyc(0, 0, 1, 0, 0, ""); idle(4, 0);
        cyc(1, 0, 0, 0, 0, "R2 sticky lock-error");
        // R3 event in the read cycle
        cyc(1, 1, 1, 0, 0, "R3 read with coincident events");
        idle(1, 0);
        cyc(1, 0, 0, 0, 0, "R3 coincident events kept");
        // R4 maximum progress
        cyc(0, 0, 0, 1, 0, ""); cyc(0, 0, 0, 3, 0, ""); cyc(0, 0, 0, 2, 0, "");
        cyc(1, 0, 0, 2, 0, "R4 maximum of 1,3,2");
        // R5 reload with the live code
        idle(3, 0);
        cyc(1, 0, 0, 0, 0, "R5 reload kept stage 2");
        cyc(0, 0, 0, 8, 0, ""); idle(2, 0);
        cyc(1, 0, 0, 0, 0, "R4 done stage reported");
        // R6 illegal codes
        cyc(0, 0, 0, 5, 0, ""); cyc(0, 0, 0, 4'd12, 0, ""); cyc(0, 0, 0, 4'd15, 0, "");
        cyc(1, 0, 0, 4'd9, 0, "R6 illegal codes ignored");
        cyc(1, 0, 0, 0, 0, "R6 illegal code reloads idle");
        // R7 10 Mb/s masking
        cyc(0, 1, 1, 0, 0, ""); idle(2, 0);
        cyc(1, 0, 0, 0, 1, "R7 flags masked in 10M");
        cyc(1, 0, 0, 0, 0, "R7 flags cleared by masked read");
        // R8 hold between reads checked by monitor
        idle(6, 0);
        // random phase
        for (int i = 0; i < 400; i++) begin
            cyc(($urandom % 4) == 0, ($urandom % 7) == 0, ($urandom % 9) == 0,
                4'($urandom % 11), ($urandom % 5) == 0, "R4 random");
        end
        idle(3, 0);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8: %0d words missing, expected 0", exp_q.size());
        end
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule